// File: doc/BRIEF.md
# CPU Bus Chip-Select Glue with Boot Overlay

This block is the glue logic between an 8-bit CPU with separate memory and I/O request lines and its memory and peripheral chips. It qualifies the active-low request and read/write lines into four strobes. From those strobes and the address bus it makes the active-low chip selects for the boot ROM, the RAM, a serial controller and a general I/O header. It also passes two register-select bits through to the serial controller.

At power-up the ROM overlays the bottom of the memory map for reads. Boot code copies itself to RAM and then does one I/O write into the overlay-release port block. That write sets a sticky latch, and from then on RAM answers the whole map. Only a cold reset clears the latch.

A two-bit control register, written by a host, holds the CPU and the peripherals in reset after power-up until the host releases them. A warm-reset input restarts only the CPU. The bus side is plain combinational decoding: there is no data stream and no handshake.

Top module: `cpu_bus_glue`

## Requirements
- R1: A chip select goes low only while its qualifying strobe is active. I/O selects need iorq_n low together with rd_n or wr_n low. rom_cs_n needs mreq_n and rd_n low. ram_cs_n needs mreq_n low together with rd_n or wr_n low. With no strobe active, every select is high.
- R2: I/O decoding uses only addr[7:0]. It is enabled only when addr[7] and addr[6] are both 0, and addr[5:3] then picks one of eight 8-port blocks. addr[15:8] has no effect on I/O decoding.
- R3: sio_cs_n is low for an I/O read or write at ports 0x00 to 0x07. sio_ab_sel always equals addr[0], and sio_cd_sel always equals addr[1].
- R4: gio_cs_n is low for an I/O read or write at ports 0x10 to 0x17, and is high for every other port.
- R5: An I/O write at any port from 0x38 to 0x3F sets the overlay latch at the next rising clk edge. An I/O read there does not set it. An I/O write there with addr[7:6] not 0 does not set it.
- R6: While the latch is clear, a memory read below 0x2000 drives rom_cs_n low and ram_cs_n high. While the latch is set, the same read drives ram_cs_n low and rom_cs_n high.
- R7: Memory writes at any address select RAM, whatever the latch state. Memory reads at 0x2000 and above select RAM.
- R8: The overlay latch and the control register are cleared only by cold_rst_n low. A warm reset leaves the latch unchanged.
- R9: The control register resets to 00, and a host write with host_ctl_we high loads host_ctl_d at the rising clk edge. Bit 0 is the cold-release bit and bit 1 is the warm-release bit. periph_rst_n = cold_rst_n & bit0. cpu_rst_n = cold_rst_n & warm_rst_n & bit0 & bit1.
- R10: warm_rst_n low forces cpu_rst_n low and leaves periph_rst_n unchanged.
- R11: rom_cs_n and ram_cs_n are never both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Glue clock |
| cold_rst_n | input | 1 | Cold reset, active low, asynchronous |
| warm_rst_n | input | 1 | Warm reset of the CPU only, active low |
| addr | input | 16 | CPU address bus |
| mreq_n | input | 1 | Memory request, active low |
| iorq_n | input | 1 | I/O request, active low |
| rd_n | input | 1 | Read, active low |
| wr_n | input | 1 | Write, active low |
| host_ctl_we | input | 1 | Host write enable for the control register |
| host_ctl_d | input | 2 | Host control data (bit0 cold release, bit1 warm release) |
| rom_cs_n | output | 1 | ROM chip select, active low |
| ram_cs_n | output | 1 | RAM chip select, active low |
| sio_cs_n | output | 1 | Serial controller chip select, active low |
| sio_ab_sel | output | 1 | Serial channel select (addr[0]) |
| sio_cd_sel | output | 1 | Serial control/data select (addr[1]) |
| gio_cs_n | output | 1 | General I/O chip select, active low |
| cpu_rst_n | output | 1 | CPU reset, active low |
| periph_rst_n | output | 1 | Peripheral reset, active low |

## Verification
The bench builds the block with its default parameters: a 16-bit address, an 8-bit I/O port space with 8-port blocks, and an 8 KB overlay window. With these values all 256 I/O ports can be swept under read, write and idle strobes, each with a varying upper address byte. The memory map is sampled across its full range, including both edges of the overlay window, before and after the latch is set. The same settings let the bench reach the latch's set, hold and clear paths through warm and cold resets.

// File: rtl/glue_pkg.sv
package glue_pkg;
  typedef struct packed {
    logic io_rd;
    logic io_wr;
    logic mem_rd;
    logic mem_wr;
  } strobe_t;
endpackage

// File: rtl/glue_strobes.sv
module glue_strobes
  import glue_pkg::*;
(
  input  logic    mreq_n,
  input  logic    iorq_n,
  input  logic    rd_n,
  input  logic    wr_n,
  output strobe_t stb
);
  always_comb begin
    stb.io_rd  = !iorq_n && !rd_n;
    stb.io_wr  = !iorq_n && !wr_n;
    stb.mem_rd = !mreq_n && !rd_n;
    stb.mem_wr = !mreq_n && !wr_n;
  end
endmodule

// File: rtl/glue_io_decode.sv
module glue_io_decode
  import glue_pkg::*;
#(
  parameter int IO_W     = 8,
  parameter int BLK_BITS = 3,
  parameter int SEL_BITS = 3,
  parameter int SIO_BLK  = 0,
  parameter int GIO_BLK  = 2,
  parameter int SWAP_BLK = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [IO_W-1:0] io_addr,
  input  strobe_t         stb,
  output logic            sio_hit,
  output logic            gio_hit,
  output logic            swap_hit
);
  localparam int EN_BITS = IO_W - BLK_BITS - SEL_BITS;
  localparam int NBLK    = 1 << SEL_BITS;

  logic            io_any;
  logic            space_en;
  logic [NBLK-1:0] blk;

  assign io_any = stb.io_rd | stb.io_wr;

  generate
    if (EN_BITS > 0) begin : g_space_gate
      assign space_en = io_any && (io_addr[IO_W-1 -: EN_BITS] == '0);
    end else begin : g_space_full
      assign space_en = io_any;
    end
    for (genvar g = 0; g < NBLK; g++) begin : g_blk
      assign blk[g] = space_en && (io_addr[BLK_BITS +: SEL_BITS] == SEL_BITS'(g));
    end
  endgenerate

  assign sio_hit  = blk[SIO_BLK];
  assign gio_hit  = blk[GIO_BLK];
  assign swap_hit = blk[SWAP_BLK] & stb.io_wr;

  // R2: at most one port block is decoded at a time
  a_r2_one_block: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(blk));
  // R5: a release hit only ever comes from an I/O write
  a_r5_swap_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    swap_hit |-> stb.io_wr);
endmodule

// File: rtl/glue_mem_select.sv
module glue_mem_select
  import glue_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int ROM_BITS = 13
) (
  input  logic [ADDR_W-1:0] addr,
  input  strobe_t           stb,
  input  logic              swap,
  output logic              rom_sel,
  output logic              ram_sel
);
  logic in_window;

  assign in_window = (addr[ADDR_W-1:ROM_BITS] == '0);
  assign rom_sel   = stb.mem_rd && in_window && !swap;
  assign ram_sel   = (stb.mem_rd || stb.mem_wr) && !rom_sel;
endmodule

// File: rtl/glue_boot_ctl.sv
module glue_boot_ctl #(
  parameter int CTL_W = 2
) (
  input  logic             clk,
  input  logic             cold_rst_n,
  input  logic             warm_rst_n,
  input  logic             swap_set,
  input  logic             host_we,
  input  logic [CTL_W-1:0] host_d,
  output logic             swap,
  output logic             cpu_rst_n,
  output logic             periph_rst_n
);
  logic [CTL_W-1:0] ctl_q;

  always_ff @(posedge clk or negedge cold_rst_n) begin
    if (!cold_rst_n) begin
      swap  <= 1'b0;
      ctl_q <= '0;
    end else begin
      if (swap_set) swap <= 1'b1;
      if (host_we)  ctl_q <= host_d;
    end
  end

  assign periph_rst_n = cold_rst_n & ctl_q[0];
  assign cpu_rst_n    = cold_rst_n & warm_rst_n & (&ctl_q);

  // R8: once released, the overlay stays released until cold reset
  a_r8_swap_sticky: assert property (@(posedge clk) disable iff (!cold_rst_n)
    swap |=> swap);
  // R5: the latch only rises after a release write
  a_r5_swap_cause: assert property (@(posedge clk) disable iff (!cold_rst_n)
    !swap ##1 swap |-> $past(swap_set));
  // R10: warm reset always holds the CPU
  a_r10_warm_holds_cpu: assert property (@(posedge clk) disable iff (!cold_rst_n)
    !warm_rst_n |-> !cpu_rst_n);
  // R9: the CPU never runs while peripherals are held
  a_r9_cpu_after_periph: assert property (@(posedge clk) disable iff (!cold_rst_n)
    cpu_rst_n |-> periph_rst_n);
endmodule

// File: rtl/cpu_bus_glue.sv
module cpu_bus_glue
  import glue_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int IO_W     = 8,
  parameter int BLK_BITS = 3,
  parameter int SEL_BITS = 3,
  parameter int ROM_BITS = 13,
  parameter int SIO_BLK  = 0,
  parameter int GIO_BLK  = 2,
  parameter int SWAP_BLK = 7
) (
  input  logic              clk,
  input  logic              cold_rst_n,
  input  logic              warm_rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              mreq_n,
  input  logic              iorq_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              host_ctl_we,
  input  logic [1:0]        host_ctl_d,
  output logic              rom_cs_n,
  output logic              ram_cs_n,
  output logic              sio_cs_n,
  output logic              sio_ab_sel,
  output logic              sio_cd_sel,
  output logic              gio_cs_n,
  output logic              cpu_rst_n,
  output logic              periph_rst_n
);
  localparam int EN_BITS = IO_W - BLK_BITS - SEL_BITS;

  strobe_t stb;
  logic    sio_hit, gio_hit, swap_hit, swap, rom_sel, ram_sel;

  glue_strobes i_strobes (
    .mreq_n(mreq_n), .iorq_n(iorq_n), .rd_n(rd_n), .wr_n(wr_n), .stb(stb)
  );

  glue_io_decode #(
    .IO_W(IO_W), .BLK_BITS(BLK_BITS), .SEL_BITS(SEL_BITS),
    .SIO_BLK(SIO_BLK), .GIO_BLK(GIO_BLK), .SWAP_BLK(SWAP_BLK)
  ) i_io_decode (
    .clk(clk), .rst_n(cold_rst_n), .io_addr(addr[IO_W-1:0]), .stb(stb),
    .sio_hit(sio_hit), .gio_hit(gio_hit), .swap_hit(swap_hit)
  );

  glue_mem_select #(.ADDR_W(ADDR_W), .ROM_BITS(ROM_BITS)) i_mem_select (
    .addr(addr), .stb(stb), .swap(swap), .rom_sel(rom_sel), .ram_sel(ram_sel)
  );

  glue_boot_ctl #(.CTL_W(2)) i_boot_ctl (
    .clk(clk), .cold_rst_n(cold_rst_n), .warm_rst_n(warm_rst_n),
    .swap_set(swap_hit), .host_we(host_ctl_we), .host_d(host_ctl_d),
    .swap(swap), .cpu_rst_n(cpu_rst_n), .periph_rst_n(periph_rst_n)
  );

  assign rom_cs_n   = !rom_sel;
  assign ram_cs_n   = !ram_sel;
  assign sio_cs_n   = !sio_hit;
  assign gio_cs_n   = !gio_hit;
  assign sio_ab_sel = addr[0];
  assign sio_cd_sel = addr[1];

  // R11: memory selects are mutually exclusive
  a_r11_mem_excl: assert property (@(posedge clk) disable iff (!cold_rst_n)
    !(!rom_cs_n && !ram_cs_n));
  // R1: ROM select needs a memory read on the pins
  a_r1_rom_qualified: assert property (@(posedge clk) disable iff (!cold_rst_n)
    !rom_cs_n |-> (!mreq_n && !rd_n));
  // R1: I/O selects need an I/O request on the pins
  a_r1_io_qualified: assert property (@(posedge clk) disable iff (!cold_rst_n)
    (!sio_cs_n || !gio_cs_n) |-> (!iorq_n && (!rd_n || !wr_n)));
  // R2: I/O selects only inside the enabled port space
  a_r2_io_space: assert property (@(posedge clk) disable iff (!cold_rst_n)
    !sio_cs_n |-> (addr[IO_W-1 -: EN_BITS] == '0));
  // R4: serial and general selects never overlap
  a_r4_io_excl: assert property (@(posedge clk) disable iff (!cold_rst_n)
    $onehot0({!sio_cs_n, !gio_cs_n}));
endmodule

// File: tb/test_cpu_bus_glue.sv
module test_cpu_bus_glue;
  logic clk = 1'b0;
  logic cold_rst_n = 1'b0, warm_rst_n = 1'b1;
  logic [15:0] addr = '0;
  logic mreq_n = 1'b1, iorq_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic host_ctl_we = 1'b0;
  logic [1:0] host_ctl_d = '0;
  logic rom_cs_n, ram_cs_n, sio_cs_n, sio_ab_sel, sio_cd_sel, gio_cs_n;
  logic cpu_rst_n, periph_rst_n;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cpu_bus_glue i_cpu_bus_glue (
    .clk(clk), .cold_rst_n(cold_rst_n), .warm_rst_n(warm_rst_n), .addr(addr),
    .mreq_n(mreq_n), .iorq_n(iorq_n), .rd_n(rd_n), .wr_n(wr_n),
    .host_ctl_we(host_ctl_we), .host_ctl_d(host_ctl_d),
    .rom_cs_n(rom_cs_n), .ram_cs_n(ram_cs_n), .sio_cs_n(sio_cs_n),
    .sio_ab_sel(sio_ab_sel), .sio_cd_sel(sio_cd_sel), .gio_cs_n(gio_cs_n),
    .cpu_rst_n(cpu_rst_n), .periph_rst_n(periph_rst_n)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%b exp=%b addr=%h time=%0t", req, act, exp, addr, $time);
    end
  endtask

  // kind: 0 idle, 1 io read, 2 io write, 3 mem read, 4 mem write, 5 io no rd/wr
  task automatic drive(input int kind, input logic [15:0] a);
    @(negedge clk);
    addr   = a;
    iorq_n = !(kind == 1 || kind == 2 || kind == 5);
    mreq_n = !(kind == 3 || kind == 4);
    rd_n   = !(kind == 1 || kind == 3);
    wr_n   = !(kind == 2 || kind == 4);
    #1;
  endtask

  task automatic host_write(input logic [1:0] d);
    @(negedge clk);
    host_ctl_we = 1'b1; host_ctl_d = d;
    @(negedge clk);
    host_ctl_we = 1'b0;
    #1;
  endtask

  task automatic mem_check(input string req, input logic swapped, input logic [15:0] a);
    drive(3, a);
    chk(req, rom_cs_n, !(a < 16'h2000 && !swapped));
    chk("R11", ram_cs_n, (a < 16'h2000 && !swapped));
    drive(4, a);
    chk("R7", ram_cs_n, 1'b0);
    chk("R7", rom_cs_n, 1'b1);
  endtask

  task automatic mem_sweep(input logic swapped);
    for (int i = 0; i < 256; i++) mem_check("R6", swapped, 16'(i * 257 + i));
    mem_check("R6", swapped, 16'h0000);
    mem_check("R6", swapped, 16'h1FFF);
    mem_check("R7", swapped, 16'h2000);
    mem_check("R7", swapped, 16'hFFFF);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    drive(3, 16'h0000);
    chk("R9", cpu_rst_n, 1'b0);
    chk("R9", periph_rst_n, 1'b0);
    chk("R6", rom_cs_n, 1'b0);
    @(negedge clk); cold_rst_n = 1'b1; #1;
    chk("R9", cpu_rst_n, 1'b0);
    chk("R9", periph_rst_n, 1'b0);
    host_write(2'b01);
    chk("R9", periph_rst_n, 1'b1);
    chk("R9", cpu_rst_n, 1'b0);
    host_write(2'b11);
    chk("R9", cpu_rst_n, 1'b1);

    // I/O port sweep under every strobe kind, upper byte varied
    for (int p = 0; p < 256; p++) begin
      for (int k = 0; k < 4; k++) begin
        logic [15:0] a;
        int kind;
        logic act;
        a = {8'(p * 37 + 11), 8'(p)};
        kind = (k == 0) ? 1 : (k == 1) ? 2 : (k == 2) ? 0 : 5;
        if (kind == 2 && p >= 8'h38 && p <= 8'h3F) continue;
        drive(kind, a);
        act = (kind == 1 || kind == 2);
        chk("R3", sio_cs_n, !(act && p < 8));
        chk("R4", gio_cs_n, !(act && p >= 8'h10 && p < 8'h18));
        chk("R3", sio_ab_sel, a[0]);
        chk("R3", sio_cd_sel, a[1]);
        chk("R1", rom_cs_n, 1'b1);
        chk("R1", ram_cs_n, 1'b1);
      end
    end

    mem_sweep(1'b0);

    // reads and out-of-space writes must not release the overlay
    drive(1, 16'h0039); drive(1, 16'h003F);
    drive(2, 16'h0078); drive(2, 16'hFFF8);
    drive(0, 16'h0000);
    drive(3, 16'h0100);
    chk("R5", rom_cs_n, 1'b0);

    // release write with non-zero upper byte
    drive(2, 16'hA53A);
    @(posedge clk);
    drive(0, 16'h0000);
    drive(3, 16'h0100);
    chk("R5", rom_cs_n, 1'b1);
    chk("R6", ram_cs_n, 1'b0);

    mem_sweep(1'b1);

    // warm reset: CPU only, latch kept
    @(negedge clk); warm_rst_n = 1'b0; #1;
    chk("R10", cpu_rst_n, 1'b0);
    chk("R10", periph_rst_n, 1'b1);
    repeat (3) @(posedge clk);
    @(negedge clk); warm_rst_n = 1'b1; #1;
    chk("R10", cpu_rst_n, 1'b1);
    drive(3, 16'h0000);
    chk("R8", ram_cs_n, 1'b0);
    chk("R8", rom_cs_n, 1'b1);

    // cold reset clears latch and control register
    @(negedge clk); cold_rst_n = 1'b0; #1;
    @(negedge clk); cold_rst_n = 1'b1; #1;
    chk("R8", cpu_rst_n, 1'b0);
    chk("R8", periph_rst_n, 1'b0);
    drive(3, 16'h0000);
    chk("R8", rom_cs_n, 1'b0);
    chk("R8", ram_cs_n, 1'b1);
    drive(0, 16'h0000);
    chk("R1", rom_cs_n, 1'b1);
    chk("R1", ram_cs_n, 1'b1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule